// File: doc/BRIEF.md
# Dynamic Memory Cycle Sequencer

This block sits between a host and a small dynamic storage array. It turns host requests into timed strobe sequences, and it slots periodic refresh cycles in between them. One clock stands for one relay settle step. A host request carries an operation code, a row address, write data and a fill count. The block answers with a grant when it accepts the request, holds busy while the cycle runs, and pulses done in the last step. On a read, the fetched word is on `host_rdata` when done pulses.

Each cycle kind has its own fixed step sequence. A write presents the address, pulses the write strobe, then releases. A read presents the address, raises the restore (sense) strobe, then the read strobe, then releases. A fill writes one value to a run of consecutive rows: it presents the first address once, then alternates a write-strobe step with a move step. In the move step the strobe is low while the address advances. A refresh hands the address path to an internal row counter and raises the restore strobe with no data returned. It then gives the path back and advances the counter.

The memory address comes from a latch that changes only when a new cycle presents an address, so the decoder sees no glitches between cycles. A behavioural row store with a sense latch is built in, so the whole path can be checked end to end. States: `S_IDLE`, write `S_WR_ADDR`→`S_WR_PULSE`→`S_WR_REL`, read `S_RD_ADDR`→`S_RD_RESTORE`→`S_RD_PULSE`→`S_RD_REL`, fill `S_FL_ADDR`→`S_FL_PULSE`→`S_FL_MOVE` (which goes back to `S_FL_PULSE` or to idle), and refresh `S_RF_SEL`→`S_RF_SETTLE`→`S_RF_ON`→`S_RF_HOLD`(×HOLD_STEPS)→`S_RF_OFF`→`S_RF_REL`. Every sequence returns to `S_IDLE`.

Top module: `dram_cycle_seq`

## Requirements
- R1: During and right after reset the block is idle: busy, done, grant, addr_sel and all three strobes are low.
- R2: Operation code 0 (write) runs 3 steps: the address step with no strobe, a step with only wr_strobe high and mem_wdata equal to the host data, and a release step with done high. The data is stored in the addressed row.
- R3: Operation code 1 (read) runs 4 steps: the address step, a step with only rs_strobe high, a step with only rd_strobe high, and a release step with done high and host_rdata equal to the stored row value. The read strobe always follows the restore strobe.
- R4: Operation code 2 (fill) writes host_wdata to host_cnt+1 consecutive rows, starting at host_addr and wrapping from ROWS-1 to 0. It runs 1 address step and then, per row, a step with wr_strobe high and a move step with no strobe. Done is high in the last move step, so the fill takes 2·(host_cnt+1)+1 steps.
- R5: A refresh runs 5+HOLD_STEPS steps. addr_sel is high in the first 4+HOLD_STEPS steps. rs_strobe is high in steps 3 through 3+HOLD_STEPS. The last step has busy high and addr_sel low. wr_strobe, rd_strobe and done stay low throughout.
- R6: During a refresh, mem_addr equals the refresh row counter. The counter is 0 after reset, advances by one after each refresh, and wraps from ROWS-1 to 0.
- R7: When a refresh request and a host request are both waiting in idle, the refresh runs first and the host request is not granted.
- R8: A refresh request that arrives during a host cycle does not shorten or alter that cycle. The refresh starts in the second step after the host cycle's done.
- R9: Between cycles, mem_addr holds the last address presented (for a fill, the last row written).
- R10: Operation code 3 is ignored: it is never granted and the block stays idle.
- R11: Grant is given only in idle. Busy is high from the step after grant through the final step. Done is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Host request held until granted |
| host_op | input | 2 | 0 write, 1 read, 2 fill, 3 none |
| host_addr | input | AW | Row address (first row for fill) |
| host_wdata | input | DATA_W | Write or fill data |
| host_cnt | input | AW | Fill length minus one |
| host_grant | output | 1 | Request accepted this clock |
| host_busy | output | 1 | A cycle is in progress |
| host_done | output | 1 | One-clock end-of-host-cycle pulse |
| host_rdata | output | DATA_W | Read result, valid with done |
| ref_req | input | 1 | Refresh request pulse from a timer |
| addr_sel | output | 1 | Address path owned by refresh counter |
| mem_addr | output | AW | Latched array address |
| mem_wdata | output | DATA_W | Array write data |
| wr_strobe | output | 1 | Array write strobe |
| rs_strobe | output | 1 | Restore/sense strobe |
| rd_strobe | output | 1 | Array read strobe |

## Verification
The bench builds the block with ROWS=5, DATA_W=8 and HOLD_STEPS=2. A row count that is not a power of two makes the wrap from row 4 to row 0 a real comparison, for both the refresh counter (reached after five refreshes) and a fill that starts at row 3. A two-step hold stretches the refresh to seven steps, which shows that the hold counter and the addr_sel window follow the parameter rather than a fixed count.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_FILL  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_WR_ADDR,
        S_WR_PULSE,
        S_WR_REL,
        S_RD_ADDR,
        S_RD_RESTORE,
        S_RD_PULSE,
        S_RD_REL,
        S_FL_ADDR,
        S_FL_PULSE,
        S_FL_MOVE,
        S_RF_SEL,
        S_RF_SETTLE,
        S_RF_ON,
        S_RF_HOLD,
        S_RF_OFF,
        S_RF_REL
    } seq_state_e;

endpackage

// File: rtl/seq_row_ctr.sv
module seq_row_ctr #(
    parameter int ROWS = 8,
    localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [AW-1:0] row
);

    logic [AW-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (inc) begin
            row_q <= (row_q == AW'(ROWS - 1)) ? '0 : row_q + AW'(1);
        end
    end

    assign row = row_q;

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row_q) < ROWS); // R6

endmodule

// File: rtl/seq_row_store.sv
module seq_row_store #(
    parameter int ROWS   = 8,
    parameter int DATA_W = 8,
    localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rs,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] row_q [ROWS];
    logic [DATA_W-1:0] picked;
    logic [DATA_W-1:0] sense_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (wr && addr == AW'(r)) begin
                row_q[r] <= wdata;
            end
        end
    end

    always_comb begin
        picked = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (addr == AW'(r)) begin
                picked = row_q[r];
            end
        end
    end

    // The restore strobe loads the sense latch; the read strobe drives it out.
    always_ff @(posedge clk) begin
        if (rs) begin
            sense_q <= picked;
        end
    end

    assign rdata = rd ? sense_q : '0;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr, rs, rd}) <= 1); // R2

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int ROWS       = 8,
    parameter int DATA_W     = 8,
    parameter int HOLD_STEPS = 1,
    localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int HW = (HOLD_STEPS > 1) ? $clog2(HOLD_STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic [1:0]        host_op,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [AW-1:0]     host_cnt,
    input  logic              ref_req,
    input  logic [AW-1:0]     ref_row,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              host_grant,
    output logic              host_busy,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic              ref_inc,
    output logic              addr_sel,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wr_strobe,
    output logic              rs_strobe,
    output logic              rd_strobe
);

    seq_state_e        state_q, state_n;
    logic              ref_pend_q;
    logic              ref_go;
    logic              op_ok;
    logic              last_row;
    logic [AW-1:0]     addr_q;
    logic [AW-1:0]     remain_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [HW-1:0]     hold_q;

    assign ref_go   = ref_pend_q | ref_req;
    assign op_ok    = op_e'(host_op) != OP_NONE;
    assign last_row = (remain_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (ref_go) begin
                    state_n = S_RF_SEL;
                end else if (host_req && op_ok) begin
                    unique case (op_e'(host_op))
                        OP_WRITE: state_n = S_WR_ADDR;
                        OP_READ:  state_n = S_RD_ADDR;
                        OP_FILL:  state_n = S_FL_ADDR;
                        default:  state_n = S_IDLE;
                    endcase
                end
            end
            S_WR_ADDR:    state_n = S_WR_PULSE;
            S_WR_PULSE:   state_n = S_WR_REL;
            S_WR_REL:     state_n = S_IDLE;
            S_RD_ADDR:    state_n = S_RD_RESTORE;
            S_RD_RESTORE: state_n = S_RD_PULSE;
            S_RD_PULSE:   state_n = S_RD_REL;
            S_RD_REL:     state_n = S_IDLE;
            S_FL_ADDR:    state_n = S_FL_PULSE;
            S_FL_PULSE:   state_n = S_FL_MOVE;
            S_FL_MOVE:    state_n = last_row ? S_IDLE : S_FL_PULSE;
            S_RF_SEL:     state_n = S_RF_SETTLE;
            S_RF_SETTLE:  state_n = S_RF_ON;
            S_RF_ON:      state_n = S_RF_HOLD;
            S_RF_HOLD:    state_n = (hold_q == HW'(HOLD_STEPS - 1)) ? S_RF_OFF : S_RF_HOLD;
            S_RF_OFF:     state_n = S_RF_REL;
            S_RF_REL:     state_n = S_IDLE;
            default:      state_n = S_IDLE;
        endcase
    end

    // Datapath registers: address latch, data, counters, pending refresh
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_pend_q <= 1'b0;
            addr_q     <= '0;
            remain_q   <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            hold_q     <= '0;
        end else begin
            if (state_q == S_IDLE && ref_go) begin
                ref_pend_q <= 1'b0;
                addr_q     <= ref_row;
            end else begin
                ref_pend_q <= ref_go;
                if (host_grant) begin
                    addr_q   <= host_addr;
                    remain_q <= host_cnt;
                    wdata_q  <= host_wdata;
                end else if (state_q == S_FL_MOVE && !last_row) begin
                    addr_q   <= (addr_q == AW'(ROWS - 1)) ? '0 : addr_q + AW'(1);
                    remain_q <= remain_q - AW'(1);
                end
            end
            if (state_q == S_RD_PULSE) begin
                rdata_q <= mem_rdata;
            end
            if (state_q == S_RF_ON) begin
                hold_q <= '0;
            end else if (state_q == S_RF_HOLD) begin
                hold_q <= hold_q + HW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        host_grant = (state_q == S_IDLE) && host_req && op_ok && !ref_go;
        host_busy  = (state_q != S_IDLE);
        host_done  = 1'b0;
        wr_strobe  = 1'b0;
        rs_strobe  = 1'b0;
        rd_strobe  = 1'b0;
        addr_sel   = 1'b0;
        ref_inc    = 1'b0;
        unique case (state_q)
            S_WR_PULSE, S_FL_PULSE: wr_strobe = 1'b1;
            S_WR_REL, S_RD_REL:     host_done = 1'b1;
            S_FL_MOVE:              host_done = last_row;
            S_RD_RESTORE:           rs_strobe = 1'b1;
            S_RD_PULSE:             rd_strobe = 1'b1;
            S_RF_SEL, S_RF_SETTLE, S_RF_OFF: addr_sel = 1'b1;
            S_RF_ON, S_RF_HOLD: begin
                addr_sel  = 1'b1;
                rs_strobe = 1'b1;
            end
            S_RF_REL:               ref_inc = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
    assign host_rdata = rdata_q;

    AST_RD_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> $past(rs_strobe)); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done); // R11

    AST_REF_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        addr_sel |-> (!wr_strobe && !rd_strobe && !host_done)); // R5

    AST_REF_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_sel && rs_strobe) |-> $stable(mem_addr)); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && state_n == S_IDLE) |=> $stable(mem_addr)); // R9

    AST_GRANT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant |=> host_busy); // R11

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq #(
    parameter int ROWS       = 8,
    parameter int DATA_W     = 8,
    parameter int HOLD_STEPS = 1,
    localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic [1:0]        host_op,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [AW-1:0]     host_cnt,
    output logic              host_grant,
    output logic              host_busy,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ref_req,
    output logic              addr_sel,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wr_strobe,
    output logic              rs_strobe,
    output logic              rd_strobe
);

    logic [AW-1:0]     ref_row;
    logic              ref_inc;
    logic [DATA_W-1:0] store_rdata;

    seq_row_ctr #(.ROWS(ROWS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_inc),
        .row   (ref_row)
    );

    seq_fsm #(
        .ROWS       (ROWS),
        .DATA_W     (DATA_W),
        .HOLD_STEPS (HOLD_STEPS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_op    (host_op),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_cnt   (host_cnt),
        .ref_req    (ref_req),
        .ref_row    (ref_row),
        .mem_rdata  (store_rdata),
        .host_grant (host_grant),
        .host_busy  (host_busy),
        .host_done  (host_done),
        .host_rdata (host_rdata),
        .ref_inc    (ref_inc),
        .addr_sel   (addr_sel),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .wr_strobe  (wr_strobe),
        .rs_strobe  (rs_strobe),
        .rd_strobe  (rd_strobe)
    );

    seq_row_store #(.ROWS(ROWS), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .wr    (wr_strobe),
        .rs    (rs_strobe),
        .rd    (rd_strobe),
        .rdata (store_rdata)
    );

endmodule

// File: tb/dram_cycle_seq_test.sv
module dram_cycle_seq_test;

    localparam int ROWS = 5;
    localparam int DW   = 8;
    localparam int H    = 2;
    localparam int AW   = $clog2(ROWS);

    typedef struct {
        int op;
        int addr;
        int data;
        int cnt;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic [1:0]    host_op = 2'd0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [AW-1:0] host_cnt = '0;
    logic          ref_req = 1'b0;
    logic          host_grant, host_busy, host_done;
    logic [DW-1:0] host_rdata;
    logic          addr_sel, wr_strobe, rs_strobe, rd_strobe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int   n_checks = 0;
    int   n_fail = 0;
    int   model [ROWS];
    exp_t sbq [$];
    int   ref_cnt = 0;

    always #10 clk = ~clk;

    dram_cycle_seq #(.ROWS(ROWS), .DATA_W(DW), .HOLD_STEPS(H)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_op(host_op),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_cnt(host_cnt),
        .host_grant(host_grant), .host_busy(host_busy), .host_done(host_done),
        .host_rdata(host_rdata), .ref_req(ref_req), .addr_sel(addr_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_strobe(wr_strobe),
        .rs_strobe(rs_strobe), .rd_strobe(rd_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: push the expected item, then raise the request
    task automatic start_op(input int op, input int addr, input int data, input int cnt);
        exp_t e;
        e.op = op; e.addr = addr; e.cnt = cnt;
        e.data = (op == 1) ? model[addr] : data;
        if (op == 0) model[addr] = data;
        if (op == 2) begin
            for (int k = 0; k <= cnt; k++) model[(addr + k) % ROWS] = data;
        end
        sbq.push_back(e);
        @(posedge clk); #1;
        host_req = 1'b1; host_op = 2'(op); host_addr = AW'(addr);
        host_wdata = DW'(data); host_cnt = AW'(cnt);
    endtask

    task automatic wait_grant();
        do @(negedge clk); while (!host_grant);
        @(posedge clk); #1;
        host_req = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!host_done);
    endtask

    task automatic do_op(input int op, input int addr, input int data, input int cnt);
        start_op(op, addr, data, cnt);
        wait_grant();
        wait_done();
    endtask

    task automatic refresh_once();
        @(posedge clk); #1; ref_req = 1'b1;
        @(posedge clk); #1; ref_req = 1'b0;
        repeat (H + 8) @(posedge clk);
    endtask

    // Monitor: host cycles, popped on grant, compared step by step
    bit   act = 0;
    int   step = 0;
    int   total = 0;
    exp_t cur;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!act && host_grant) begin
                if (sbq.size() == 0) begin
                    chk(0, "R11 grant without request", 1, 0);
                end else begin
                    cur = sbq.pop_front();
                    act = 1; step = 0;
                    total = (cur.op == 0) ? 3 : (cur.op == 1) ? 4 : 2 * (cur.cnt + 1) + 1;
                end
            end else if (act) begin
                int ev;
                string tag;
                step++;
                tag = (cur.op == 0) ? "R2" : (cur.op == 1) ? "R3" : "R4";
                ev = 0;
                if (cur.op == 0 && step == 2) ev = 4;
                if (cur.op == 1 && step == 2) ev = 2;
                if (cur.op == 1 && step == 3) ev = 1;
                if (cur.op == 2 && step >= 2 && step % 2 == 0) ev = 4;
                chk({wr_strobe, rs_strobe, rd_strobe} == 3'(ev), {tag, " strobes"},
                    int'({wr_strobe, rs_strobe, rd_strobe}), ev);
                chk(host_busy == 1'b1, "R11 busy", int'(host_busy), 1);
                chk(host_done == (step == total), {tag, " done step"}, int'(host_done),
                    int'(step == total));
                if (step == 1) chk(int'(mem_addr) == cur.addr, {tag, " address"}, int'(mem_addr), cur.addr);
                if (ev[2]) begin
                    int ea;
                    ea = (cur.op == 2) ? (cur.addr + step / 2 - 1) % ROWS : cur.addr;
                    chk(int'(mem_addr) == ea, {tag, " write address"}, int'(mem_addr), ea);
                    chk(int'(mem_wdata) == cur.data, {tag, " write data"}, int'(mem_wdata), cur.data);
                end
                if (host_done && cur.op == 1)
                    chk(int'(host_rdata) == cur.data, "R3 read data", int'(host_rdata), cur.data);
                if (host_done || step >= total) act = 0;
            end
        end
    end

    // Monitor: refresh cycles
    bit prev_sel = 0;
    int rstep = 0;
    int rs_seen = 0;
    int exp_row = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_sel) begin
                if (!prev_sel) begin rstep = 0; rs_seen = 0; end
                rstep++;
                chk(!wr_strobe && !rd_strobe && !host_done, "R5 no data strobe", 1, 0);
                chk(rs_strobe == (rstep >= 3 && rstep <= 3 + H - 1 + 1 - 1 + 0 + (H > 0 ? 0 : 0) && rstep <= 2 + H + 1 - 1 + 0 ? 1'b1 : 1'b0) || 1'b0 == 1'b0 ? rs_strobe == (rstep >= 3 && rstep <= 3 + H) : 1'b0,
                    "R5 restore window", int'(rs_strobe), int'(rstep >= 3 && rstep <= 3 + H));
                if (rs_strobe) begin
                    rs_seen++;
                    chk(int'(mem_addr) == exp_row, "R6 refresh row", int'(mem_addr), exp_row);
                end
            end else if (prev_sel) begin
                chk(rstep == 4 + H, "R5 select steps", rstep, 4 + H);
                chk(rs_seen == 1 + H, "R5 restore steps", rs_seen, 1 + H);
                chk(host_busy && !rs_strobe, "R5 release step", int'(host_busy), 1);
                exp_row = (exp_row + 1) % ROWS;
                ref_cnt++;
            end
            prev_sel = addr_sel;
        end
    end

    bit finished = 0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({host_busy, host_done, host_grant, addr_sel, wr_strobe, rs_strobe, rd_strobe} == 7'd0,
            "R1 in reset", 1, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk({host_busy, host_done, host_grant, addr_sel, wr_strobe, rs_strobe, rd_strobe} == 7'd0,
            "R1 after reset", 1, 0);

        // R2 / R3: write then read back several patterns
        do_op(0, 0, 8'h11, 0);
        do_op(0, 1, 8'hA5, 0);
        do_op(0, 2, 8'h3C, 0);
        do_op(0, 4, 8'hFF, 0);
        do_op(1, 0, 0, 0);
        do_op(1, 1, 0, 0);
        do_op(1, 2, 0, 0);
        do_op(1, 4, 0, 0);

        // R9: address latch holds while idle
        repeat (4) @(negedge clk);
        chk(int'(mem_addr) == 4, "R9 held after read", int'(mem_addr), 4);

        // R4: fill, plain and wrapping
        do_op(2, 1, 8'h5A, 2);
        repeat (3) @(negedge clk);
        chk(int'(mem_addr) == 3, "R9 held after fill", int'(mem_addr), 3);
        do_op(1, 1, 0, 0);
        do_op(1, 3, 0, 0);
        do_op(1, 0, 0, 0);
        do_op(2, 3, 8'h66, 2);
        repeat (2) @(negedge clk);
        chk(int'(mem_addr) == 0, "R4 fill wraps to row 0", int'(mem_addr), 0);
        do_op(1, 4, 0, 0);
        do_op(1, 0, 0, 0);
        do_op(1, 2, 0, 0);

        // R10: op 3 ignored
        @(posedge clk); #1;
        host_req = 1'b1; host_op = 2'd3; host_addr = AW'(2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!host_grant && !host_busy, "R10 op 3 ignored", int'(host_grant | host_busy), 0);
        end
        @(posedge clk); #1; host_req = 1'b0;

        // R7: refresh wins over a simultaneous host request
        start_op(1, 2, 0, 0);
        ref_req = 1'b1;
        @(negedge clk);
        chk(!host_grant, "R7 host not granted", int'(host_grant), 0);
        @(posedge clk); #1; ref_req = 1'b0;
        @(negedge clk);
        chk(addr_sel, "R7 refresh first", int'(addr_sel), 1);
        wait_grant();
        wait_done();
        chk(ref_cnt == 1, "R7 one refresh before read", ref_cnt, 1);

        // R8: refresh request during a host cycle waits
        start_op(1, 4, 0, 0);
        wait_grant();
        ref_req = 1'b1;
        @(posedge clk); #1; ref_req = 1'b0;
        wait_done();
        chk(ref_cnt == 1 && !addr_sel, "R8 no preemption", ref_cnt, 1);
        @(negedge clk);
        chk(!addr_sel, "R8 idle step", int'(addr_sel), 0);
        @(negedge clk);
        chk(addr_sel, "R8 refresh follows", int'(addr_sel), 1);
        repeat (H + 8) @(posedge clk);
        chk(ref_cnt == 2, "R8 refresh completed", ref_cnt, 2);

        // R6: run past the wrap of the row counter
        for (int i = 0; i < ROWS + 1; i++) refresh_once();
        chk(ref_cnt == ROWS + 3, "R6 refresh count", ref_cnt, ROWS + 3);
        chk(exp_row == (ROWS + 3) % ROWS, "R6 wrap position", exp_row, (ROWS + 3) % ROWS);

        do_op(1, 1, 0, 0);
        do_op(1, 3, 0, 0);
        repeat (3) @(posedge clk);
        chk(sbq.size() == 0 && !act, "R11 scoreboard drained", sbq.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule